// File: doc/BRIEF.md
# Branch Hazard Stall Controller

This block is the control logic for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). The pipeline has no branch prediction and no delay slot. When decode flags a valid branch, the instruction fetched just after it is held in the fetch/decode register while the branch is in execute. During that cycle a no-op is placed into the decode/execute register. If the branch is not taken, the held instruction goes on into decode, and decode sees one bubble. If the branch is taken, the held instruction is squashed and fetch is sent to the branch target. The target then reaches decode two bubbles after the branch.

The block owns the fetch program counter. It drives the enable and source select of that counter, and the hold, flush and no-op controls of the two pipeline registers around decode. It remembers two things: whether a branch sits in execute, and whether the fetch/decode slot was squashed. A branch flag that arrives from a stalled or squashed slot is ignored.

Top module: `branch_stall_ctrl`

## Requirements
- R1: While reset is asserted, `ifid_hold`, `ifid_flush` and `idex_bubble` are low and `fetch_pc` equals the reset address (0x100 by default).
- R2: With no branch in execute, `pc_we` is 1, `pc_sel` is 0 (sequential) and `fetch_pc` advances by 4 every cycle.
- R3: A branch flag from a valid decode slot makes `idex_bubble` high in the next cycle, while that branch is in execute.
- R4: While a branch is in execute and not resolved as taken, `ifid_hold` is 1 and `pc_we` is 0. A not-taken branch lets the held instruction enter decode two cycles after the branch entered decode (one bubble).
- R5: When execute reports the pending branch as resolved and taken, `pc_sel` (1 = target), `pc_we` and `ifid_flush` are high in that same cycle and `ifid_hold` is low. `fetch_pc` holds the target in the next cycle, and the target enters decode three cycles after the branch (two bubbles).
- R6: In the cycle after a flush, `idex_bubble` is high and the branch flag of the squashed slot is ignored, so no new branch becomes pending from it.
- R7: The branch flag of the instruction held during a stall is ignored during that stall cycle.
- R8: A branch held behind a not-taken branch is treated as a new branch once it enters decode.
- R9: `ex_taken` and `ex_resolved` cause no redirect unless a branch from decode is in execute.
- R10: Instructions after the branch are delayed by the same penalty as the first one, with no further gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_is_branch | input | 1 | Instruction in the fetch/decode register is a branch |
| ex_resolved | input | 1 | Execute stage has resolved its branch this cycle |
| ex_taken | input | 1 | Outcome of the branch in execute (1 = taken) |
| br_target | input | PC_W | Target address of the branch in execute |
| fetch_pc | output | PC_W | Address fetched this cycle |
| pc_we | output | 1 | Fetch PC update enable |
| pc_sel | output | 1 | Next PC source: 0 = PC+4, 1 = branch target |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_flush | output | 1 | Squash the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The interesting coincidence is a taken resolution in the same cycle that the fetch/decode register holds another branch. In that cycle the redirect must win over the hold, the held branch must be squashed, and its flag must be ignored twice. The bench builds this from a fetch-stream program with a taken branch directly followed by another branch, and with a not-taken branch directly followed by a taken one. A small pipeline shell, driven by the block's own controls, records the cycle in which each address enters decode. Those cycles are compared with values counted by hand from the requirements. A behavioural model predicts every output on every clock.

// File: rtl/branch_stall_ctrl.sv
module branch_stall_ctrl #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = 'h100,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_is_branch,
  input  logic            ex_resolved,
  input  logic            ex_taken,
  input  logic [PC_W-1:0] br_target,
  output logic [PC_W-1:0] fetch_pc,
  output logic            pc_we,
  output logic            pc_sel,
  output logic            ifid_hold,
  output logic            ifid_flush,
  output logic            idex_bubble
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  logic br_in_ex;
  logic slot_squashed;
  logic redirect;
  logic id_branch_ok;

  assign redirect     = br_in_ex & ex_resolved & ex_taken;
  assign id_branch_ok = id_is_branch & ~br_in_ex & ~slot_squashed;

  assign ifid_hold   = br_in_ex & ~redirect;
  assign ifid_flush  = redirect;
  assign idex_bubble = br_in_ex | slot_squashed;
  assign pc_sel      = redirect;
  assign pc_we       = ~ifid_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_in_ex      <= 1'b0;
      slot_squashed <= 1'b0;
      fetch_pc      <= RESET_PC;
    end else begin
      br_in_ex      <= br_in_ex ? ~ex_resolved : id_branch_ok;
      slot_squashed <= redirect;
      if (pc_we)
        fetch_pc <= pc_sel ? br_target : fetch_pc + STEP_V;
    end
  end
endmodule

// File: rtl/branch_stall_ctrl_chk.sv
module branch_stall_ctrl_chk #(
  parameter int PC_W = 32,
  parameter int STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            id_is_branch,
  input logic            ex_resolved,
  input logic            ex_taken,
  input logic [PC_W-1:0] br_target,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pc_we,
  input logic            pc_sel,
  input logic            ifid_hold,
  input logic            ifid_flush,
  input logic            idex_bubble
);
  always @(posedge clk)
    if (!rst_n)
      p_reset_quiet_r1: assert (!ifid_hold && !ifid_flush && !idex_bubble);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && !pc_sel) |=> fetch_pc == $past(fetch_pc) + PC_W'(STEP));

  p_branch_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_branch && !idex_bubble) |=> idex_bubble);

  p_hold_freezes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_hold |-> (!pc_we && idex_bubble));

  p_nt_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ifid_hold && ex_resolved) |=> !idex_bubble);

  p_redirect_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |=> fetch_pc == $past(br_target));

  p_flush_not_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |-> (!ifid_hold && pc_we && pc_sel));

  p_squash_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_flush |=> idex_bubble ##1 !idex_bubble);

  p_redirect_qualified_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |-> (ex_resolved && ex_taken && idex_bubble));
endmodule

bind branch_stall_ctrl branch_stall_ctrl_chk #(.PC_W(PC_W), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_is_branch(id_is_branch),
  .ex_resolved(ex_resolved), .ex_taken(ex_taken), .br_target(br_target),
  .fetch_pc(fetch_pc), .pc_we(pc_we), .pc_sel(pc_sel),
  .ifid_hold(ifid_hold), .ifid_flush(ifid_flush), .idex_bubble(idex_bubble)
);

// File: tb/test_branch_stall_ctrl.sv
`timescale 1ns/1ps
module test_branch_stall_ctrl;
  localparam int PC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_is_branch = 1'b0, ex_resolved = 1'b0, ex_taken = 1'b0;
  logic [PC_W-1:0] br_target = '0;
  logic [PC_W-1:0] fetch_pc;
  logic pc_we, pc_sel, ifid_hold, ifid_flush, idex_bubble;

  always #4 clk = ~clk;

  branch_stall_ctrl i_branch_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .id_is_branch(id_is_branch),
    .ex_resolved(ex_resolved), .ex_taken(ex_taken), .br_target(br_target),
    .fetch_pc(fetch_pc), .pc_we(pc_we), .pc_sel(pc_sel),
    .ifid_hold(ifid_hold), .ifid_flush(ifid_flush), .idex_bubble(idex_bubble)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_br(int a);
    case (a)
      'h104, 'h20C, 'h210, 'h214, 'h304, 'h308: return 1;
      default: return 0;
    endcase
  endfunction
  function automatic bit is_taken(int a);
    return a != 'h20C;
  endfunction
  function automatic int tgt_of(int a);
    case (a)
      'h104: return 'h200;
      'h210: return 'h300;
      'h304: return 'h400;
      'h214: return 'h500;
      'h308: return 'h600;
      default: return 'hDEAD0;
    endcase
  endfunction

  int dec_at[int];

  initial begin
    int s_addr = 0; bit s_valid = 0, s_nop = 0;
    int s_ex_addr = 0; bit s_ex_br = 0;
    bit r_pend = 0, r_sq = 0; int r_pc = 'h100;
    repeat (3) @(negedge clk);
    #1;
    chk(fetch_pc == 'h100, "R1", "fetch_pc in reset", fetch_pc, 'h100);
    chk(!ifid_hold && !ifid_flush && !idex_bubble, "R1", "controls in reset",
        {ifid_hold, ifid_flush, idex_bubble}, 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 40; cyc++) begin
      bit e_redir, e_hold, e_bub, c_we, c_sel, c_hold, c_flush, c_bub; int c_pc;
      if (cyc != 0) @(negedge clk);
      id_is_branch = s_valid && is_br(s_addr);
      ex_resolved  = s_ex_br ? 1'b1 : cyc[0];
      ex_taken     = s_ex_br ? is_taken(s_ex_addr) : 1'b1;
      br_target    = s_ex_br ? PC_W'(tgt_of(s_ex_addr)) : PC_W'('h7770);
      #1;
      e_redir = r_pend && ex_resolved && ex_taken;
      e_hold  = r_pend && !e_redir;
      e_bub   = r_pend || r_sq;
      chk(fetch_pc == PC_W'(r_pc), "R2", "fetch_pc", fetch_pc, r_pc);
      chk(pc_we == !e_hold, "R4", "pc_we", pc_we, !e_hold);
      chk(pc_sel == e_redir && ifid_flush == e_redir, "R5/R9", "pc_sel/flush",
          {pc_sel, ifid_flush}, {e_redir, e_redir});
      chk(ifid_hold == e_hold, "R4", "ifid_hold", ifid_hold, e_hold);
      chk(idex_bubble == e_bub, "R3/R6", "idex_bubble", idex_bubble, e_bub);
      c_we = pc_we; c_sel = pc_sel; c_hold = ifid_hold; c_flush = ifid_flush;
      c_bub = idex_bubble; c_pc = int'(fetch_pc);
      @(posedge clk);
      // reference model
      r_pend = r_pend ? !ex_resolved : (id_is_branch && !r_sq);
      r_sq   = e_redir;
      if (e_redir) r_pc = int'(br_target);
      else if (!e_hold) r_pc = r_pc + 4;
      // pipeline shell driven by the block's controls
      if (c_bub) s_ex_br = 0;
      else begin
        s_ex_br = s_valid && !s_nop && is_br(s_addr);
        s_ex_addr = s_addr;
        if (s_valid && !s_nop && !dec_at.exists(s_addr)) dec_at[s_addr] = cyc;
      end
      if (c_flush) s_nop = 1;
      else if (!c_hold) begin s_addr = c_pc; s_valid = 1; s_nop = 0; end
      if (c_we && !c_sel) begin end
    end
    // decode-entry cycles counted from the requirements
    chk(dec_at.exists('h104) && dec_at['h104] == 2, "R2", "branch A decode", dec_at['h104], 2);
    chk(!dec_at.exists('h108), "R5", "squashed 0x108 decoded", 1, 0);
    chk(dec_at.exists('h200) && dec_at['h200] == 5, "R5", "target 0x200 decode", dec_at['h200], 5);
    chk(dec_at.exists('h208) && dec_at['h208] == 7, "R10", "0x208 decode", dec_at['h208], 7);
    chk(dec_at.exists('h20C) && dec_at['h20C] == 8, "R10", "branch B decode", dec_at['h20C], 8);
    chk(dec_at.exists('h210) && dec_at['h210] == 10, "R4", "held 0x210 decode after NT", dec_at['h210], 10);
    chk(!dec_at.exists('h214), "R7", "stalled branch 0x214 decoded", 1, 0);
    chk(!dec_at.exists('h500), "R6", "squashed branch redirected", 1, 0);
    chk(dec_at.exists('h300) && dec_at['h300] == 13, "R8", "target of held branch decode", dec_at['h300], 13);
    chk(dec_at.exists('h304) && dec_at['h304] == 14, "R10", "branch D decode", dec_at['h304], 14);
    chk(!dec_at.exists('h308) && !dec_at.exists('h600), "R6", "back-to-back squashed branch", 1, 0);
    chk(dec_at.exists('h400) && dec_at['h400] == 17, "R5", "target 0x400 decode", dec_at['h400], 17);
    chk(dec_at.exists('h404) && dec_at['h404] == 18, "R10", "0x404 decode", dec_at['h404], 18);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule